// File: doc/BRIEF.md
# Read-Through Flash Prefetch Buffer

This block sits between a memory-mapped read port and a serial flash sequencer. It keeps one aligned window of flash words in local storage. A read whose word lies inside the stored window is answered straight from that storage. Any other read discards the window. The block then asks the sequencer to refill a new window. The new window starts at the requested address rounded down to the programmed fetch size. The refill runs the flash read sequence whose ID is on a configuration input.

The reader holds a request until it sees a one-cycle `rd_ready` pulse with data. A missing request is answered as soon as its own word arrives from the sequencer, and the rest of the window keeps streaming in. Other requests wait until the refill is complete. Software that has changed flash contents invalidates the window. It does so by holding the bus-side and serial-side soft resets high together for a minimum number of cycles.

Top module: `flash_prefetch_buf`

## Requirements
- R1: After reset `rd_ready` and `fill_req` are low and no window is held, so the first read always starts a refill.
- R2: A read that hits the stored window is answered one cycle after it is first presented (`rd_ready` visible in the cycle after the sampling edge), with the stored word and no refill.
- R3: A miss raises `fill_req` with `fill_addr` equal to the byte address rounded down to the window size and `fill_seq` equal to `cfg_seq_id` at the miss. These outputs stay stable until the cycle after `fill_ack`. Data words then arrive on `fill_dv`/`fill_data` in ascending address order.
- R4: The window size in bytes is 8 times `cfg_fetch_units` rounded down to a power of two. A unit value of 0 counts as 1, and any value of 128 or more gives the 1024-byte maximum. `fill_words` is the window size divided by 4, which makes it a power of two.
- R5: A miss is answered in the cycle after the requested word is delivered, while later words of the window may still be arriving.
- R6: A request presented while a refill is in progress is not answered before the refill has delivered its last word.
- R7: The hit decision uses the window size stored at refill time, so a later change of `cfg_fetch_units` does not drop or shrink the stored window.
- R8: With `cfg_all_masters` = 1 any `rd_mid` may hit. With it at 0, only `rd_mid` equal to `cfg_master_id` may hit, and a read from any other ID is handled as a miss.
- R9: Holding `soft_rst_bus` and `soft_rst_ser` high together for 3 consecutive cycles while no refill runs clears the window, so the next read refills and returns the new flash content.
- R10: Either soft reset alone, or both together for fewer than 3 cycles, leaves the stored window and its data in place.
- R11: `rd_ready` is high for a single cycle per answered request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_seq_id | input | 4 | Flash sequence ID used for refills |
| cfg_fetch_units | input | 8 | Window size in 8-byte units |
| cfg_all_masters | input | 1 | 1: buffer serves every master ID |
| cfg_master_id | input | 4 | Master ID served when cfg_all_masters is 0 |
| soft_rst_bus | input | 1 | Bus-side soft reset |
| soft_rst_ser | input | 1 | Serial-side soft reset |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | AW | Byte address of the read (low 2 bits ignored) |
| rd_mid | input | 4 | Master ID of the read |
| rd_ready | output | 1 | One-cycle response strobe |
| rd_data | output | DW | Read data, valid with rd_ready |
| fill_req | output | 1 | Refill request to the sequencer |
| fill_ack | input | 1 | Sequencer accepts the refill request |
| fill_addr | output | AW | Window start byte address |
| fill_words | output | CW | Words to fetch |
| fill_seq | output | 4 | Sequence ID for the refill |
| fill_dv | input | 1 | Refill data word valid |
| fill_data | input | DW | Refill data word |

## Verification
The reads follow a walk through windows of 8, 16, 32 and 1024 bytes. Each step hits or misses on purpose: the same window, the next window, back to a previous window, and at its last word. This separates correct window alignment and size rounding from off-by-one range checks. Master-ID patterns alternate between the owner and another ID with the all-masters bit set and cleared. They show whether ownership gates only hits or wrongly blocks refills. Directed sequences time a miss on an inner word against the sequencer stream to separate early answer from stalling. They also apply one soft reset alone, both resets held too briefly, and both held long enough, after the flash content changed. Old or new data then shows whether the window survived.

// File: rtl/flash_prefetch_buf.sv
module flash_prefetch_buf #(
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int MAX_BYTES = 1024,
  parameter int INV_HOLD  = 3,
  parameter int CW        = $clog2(MAX_BYTES / (DW / 8)) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cfg_seq_id,
  input  logic [7:0]    cfg_fetch_units,
  input  logic          cfg_all_masters,
  input  logic [3:0]    cfg_master_id,
  input  logic          soft_rst_bus,
  input  logic          soft_rst_ser,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [3:0]    rd_mid,
  output logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          fill_req,
  input  logic          fill_ack,
  output logic [AW-1:0] fill_addr,
  output logic [CW-1:0] fill_words,
  output logic [3:0]    fill_seq,
  input  logic          fill_dv,
  input  logic [DW-1:0] fill_data
);
  localparam int BPW       = DW / 8;
  localparam int WB        = $clog2(BPW);
  localparam int WAW       = AW - WB;
  localparam int MAX_WORDS = MAX_BYTES / BPW;
  localparam int OFFW      = $clog2(MAX_WORDS);
  localparam int WPU       = 8 / BPW;
  localparam int IHW       = $clog2(INV_HOLD + 1);

  function automatic logic [CW-1:0] units_to_words(input logic [7:0] u);
    logic [CW-1:0] w;
    w = CW'(WPU);
    for (int b = 0; b < 8; b++)
      if (u[b]) w = CW'(WPU) << b;
    if (w > CW'(MAX_WORDS)) w = CW'(MAX_WORDS);
    return w;
  endfunction

  logic            win_valid, filling, pend, ready_q, fill_req_q;
  logic [WAW-1:0]  win_base;
  logic [CW-1:0]   win_words, fill_cnt;
  logic [OFFW-1:0] pend_off;
  logic [IHW-1:0]  inv_cnt;
  logic [DW-1:0]   data_q;
  logic [3:0]      fill_seq_q;
  logic [DW-1:0]   mem [MAX_WORDS];

  wire [WAW-1:0] waddr     = rd_addr[AW-1:WB];
  wire [CW-1:0]  req_words = units_to_words(cfg_fetch_units);
  wire [WAW-1:0] win_mask  = WAW'(win_words) - WAW'(1);
  wire [WAW-1:0] req_mask  = WAW'(req_words) - WAW'(1);
  wire [WAW-1:0] win_rel   = waddr & win_mask;
  wire [WAW-1:0] req_rel   = waddr & req_mask;
  wire owner_ok  = cfg_all_masters || (rd_mid == cfg_master_id);
  wire hit       = win_valid && owner_ok && ((waddr & ~win_mask) == win_base);
  wire both_rst  = soft_rst_bus && soft_rst_ser;
  wire accept    = rd_req && !ready_q && !filling && !both_rst;
  wire take_word = filling && fill_dv;
  wire last_word = take_word && (fill_cnt == win_words - CW'(1));
  wire inv_done  = both_rst && !filling && (inv_cnt == IHW'(INV_HOLD - 1));

  always_ff @(posedge clk)
    if (take_word) mem[fill_cnt[OFFW-1:0]] <= fill_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid  <= 1'b0;
      filling    <= 1'b0;
      pend       <= 1'b0;
      ready_q    <= 1'b0;
      fill_req_q <= 1'b0;
      win_base   <= '0;
      win_words  <= CW'(WPU);
      fill_cnt   <= '0;
      pend_off   <= '0;
      inv_cnt    <= '0;
      data_q     <= '0;
      fill_seq_q <= '0;
    end else begin
      ready_q <= 1'b0;
      if (fill_req_q && fill_ack) fill_req_q <= 1'b0;

      if (take_word) begin
        fill_cnt <= fill_cnt + CW'(1);
        if (last_word) filling <= 1'b0;
        if (pend && fill_cnt[OFFW-1:0] == pend_off) begin
          ready_q <= 1'b1;
          data_q  <= fill_data;
          pend    <= 1'b0;
        end
      end

      if (!both_rst)
        inv_cnt <= '0;
      else if (!filling && inv_cnt != IHW'(INV_HOLD))
        inv_cnt <= inv_cnt + IHW'(1);
      if (inv_done) win_valid <= 1'b0;

      if (accept) begin
        if (hit) begin
          ready_q <= 1'b1;
          data_q  <= mem[win_rel[OFFW-1:0]];
        end else begin
          win_valid  <= 1'b1;
          win_base   <= waddr & ~req_mask;
          win_words  <= req_words;
          fill_cnt   <= '0;
          filling    <= 1'b1;
          pend       <= 1'b1;
          pend_off   <= req_rel[OFFW-1:0];
          fill_req_q <= 1'b1;
          fill_seq_q <= cfg_seq_id;
        end
      end
    end
  end

  assign rd_ready   = ready_q;
  assign rd_data    = data_q;
  assign fill_req   = fill_req_q;
  assign fill_addr  = {win_base, {WB{1'b0}}};
  assign fill_words = win_words;
  assign fill_seq   = fill_seq_q;
endmodule

module flash_prefetch_buf_chk #(
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int MAX_BYTES = 1024,
  parameter int CW        = $clog2(MAX_BYTES / (DW / 8)) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cfg_seq_id,
  input logic          rd_ready,
  input logic          fill_req,
  input logic          fill_ack,
  input logic [AW-1:0] fill_addr,
  input logic [CW-1:0] fill_words,
  input logic [3:0]    fill_seq
);
  localparam int WB        = $clog2(DW / 8);
  localparam int MAX_WORDS = MAX_BYTES / (DW / 8);

  logic [AW-1:0] span;
  assign span = AW'(fill_words) << WB;

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr) &&
                                 $stable(fill_words) && $stable(fill_seq)));

  p_fill_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> ((fill_addr & (span - AW'(1))) == '0));

  p_fill_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> ($countones(fill_words) == 1 && fill_words <= CW'(MAX_WORDS)));

  p_seq_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> (fill_seq == $past(cfg_seq_id)));

  p_miss_no_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> !rd_ready);
endmodule

bind flash_prefetch_buf flash_prefetch_buf_chk #(
  .AW(AW), .DW(DW), .MAX_BYTES(MAX_BYTES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_seq_id(cfg_seq_id), .rd_ready(rd_ready),
  .fill_req(fill_req), .fill_ack(fill_ack), .fill_addr(fill_addr),
  .fill_words(fill_words), .fill_seq(fill_seq)
);

// File: tb/test_flash_prefetch_buf.sv
module test_flash_prefetch_buf;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    cfg_seq_id = '0;
  logic [7:0]    cfg_fetch_units = '0;
  logic          cfg_all_masters = 1'b1;
  logic [3:0]    cfg_master_id = 4'd5;
  logic          soft_rst_bus = 1'b0, soft_rst_ser = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [3:0]    rd_mid = '0;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          fill_req;
  logic          fill_ack = 1'b0;
  logic [AW-1:0] fill_addr;
  logic [CW-1:0] fill_words;
  logic [3:0]    fill_seq;
  logic          fill_dv = 1'b0;
  logic [DW-1:0] fill_data = '0;

  flash_prefetch_buf i_flash_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .cfg_seq_id(cfg_seq_id), .cfg_fetch_units(cfg_fetch_units),
    .cfg_all_masters(cfg_all_masters), .cfg_master_id(cfg_master_id),
    .soft_rst_bus(soft_rst_bus), .soft_rst_ser(soft_rst_ser),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_mid(rd_mid), .rd_ready(rd_ready), .rd_data(rd_data),
    .fill_req(fill_req), .fill_ack(fill_ack), .fill_addr(fill_addr), .fill_words(fill_words),
    .fill_seq(fill_seq), .fill_dv(fill_dv), .fill_data(fill_data)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [23:0] addr;
    logic [3:0]  mid;
    logic        all;
    logic [7:0]  units;
    logic [3:0]  seq;
    logic        miss;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{24'h000100, 4'd0, 1'b1, 8'd4,   4'd3,  1'b1, 4'd1},  // R1 cold miss
    '{24'h00011C, 4'd0, 1'b1, 8'd4,   4'd3,  1'b0, 4'd2},
    '{24'h000120, 4'd1, 1'b1, 8'd4,   4'd3,  1'b1, 4'd3},
    '{24'h000104, 4'd2, 1'b1, 8'd4,   4'd7,  1'b1, 4'd3},
    '{24'h0007FC, 4'd0, 1'b1, 8'd200, 4'd2,  1'b1, 4'd4},
    '{24'h000400, 4'd0, 1'b1, 8'd200, 4'd2,  1'b0, 4'd2},
    '{24'h0006A0, 4'd0, 1'b1, 8'd200, 4'd2,  1'b0, 4'd2},
    '{24'h000404, 4'd0, 1'b1, 8'd3,   4'd2,  1'b0, 4'd7},  // R7 stored size
    '{24'h000808, 4'd0, 1'b1, 8'd3,   4'd9,  1'b1, 4'd4},
    '{24'h00080C, 4'd0, 1'b1, 8'd3,   4'd9,  1'b0, 4'd2},
    '{24'h000810, 4'd0, 1'b1, 8'd3,   4'd9,  1'b1, 4'd3},
    '{24'h123454, 4'd0, 1'b1, 8'd0,   4'd1,  1'b1, 4'd4},
    '{24'h123450, 4'd0, 1'b1, 8'd0,   4'd1,  1'b0, 4'd2},
    '{24'h123454, 4'd5, 1'b0, 8'd0,   4'd1,  1'b0, 4'd8},  // R8 owner hits
    '{24'h123454, 4'd2, 1'b0, 8'd0,   4'd1,  1'b1, 4'd8},
    '{24'h123450, 4'd2, 1'b1, 8'd0,   4'd1,  1'b0, 4'd8},
    '{24'h123454, 4'd5, 1'b0, 8'd0,   4'd1,  1'b0, 4'd8},
    '{24'h000A34, 4'd0, 1'b1, 8'd5,   4'd15, 1'b1, 4'd4},
    '{24'h000A3C, 4'd0, 1'b1, 8'd5,   4'd15, 1'b0, 4'd2}
  };

  int nchk = 0, nfail = 0, nfills = 0, gen = 0;
  bit seq_busy = 1'b0, finished = 1'b0;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] cap_words;
  logic [3:0]    cap_seq;

  function automatic logic [31:0] fdata(input logic [21:0] w, input int g);
    return (32'(w) * 32'h01000193) ^ 32'hA5A50000 ^ (32'(g) << 24);
  endfunction

  function automatic int eff_bytes(input logic [7:0] u);
    int n = 1;
    if (u >= 8'd128) return 1024;
    if (u == 8'd0) return 8;
    while (n * 2 <= int'(u)) n = n * 2;
    return n * 8;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // sequencer model: ack, one idle cycle, then one word per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req) begin
        cap_addr = fill_addr; cap_words = fill_words; cap_seq = fill_seq;
        nfills++;
        seq_busy = 1'b1;
        fill_ack = 1'b1;
        @(negedge clk);
        fill_ack = 1'b0;
        @(negedge clk);
        for (int i = 0; i < int'(cap_words); i++) begin
          fill_dv = 1'b1;
          fill_data = fdata(cap_addr[23:2] + 22'(i), gen);
          @(negedge clk);
        end
        fill_dv = 1'b0;
        seq_busy = 1'b0;
      end
    end
  end

  task automatic do_read(input logic [23:0] a, input logic [3:0] m,
                         output logic [31:0] d, output int lat, output bit busy);
    @(negedge clk);
    rd_addr = a; rd_mid = m; rd_req = 1'b1; lat = 0;
    while (lat < 3000) begin
      @(negedge clk);
      lat++;
      if (rd_ready) break;
    end
    if (lat >= 3000) chk(1'b0, "R2", "read timeout", 32'(lat), 32'd0);
    d = rd_data;
    busy = seq_busy;
    @(posedge clk);
    #1 rd_req = 1'b0;
    @(negedge clk);
    chk(rd_ready == 1'b0, "R11", "ready longer than one cycle", 32'(rd_ready), 32'd0);
  endtask

  task automatic wait_idle();
    while (seq_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rst(input bit b, input bit s, input int n);
    @(negedge clk);
    soft_rst_bus = b; soft_rst_ser = s;
    repeat (n) @(negedge clk);
    soft_rst_bus = 1'b0; soft_rst_ser = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 150000 cycles expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lat, f0, eb;
    bit busy;
    string tg;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready == 1'b0, "R1", "rd_ready after reset", 32'(rd_ready), 32'd0);
    chk(fill_req == 1'b0, "R1", "fill_req after reset", 32'(fill_req), 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      tg = $sformatf("R%0d", v.tag);
      cfg_fetch_units = v.units;
      cfg_seq_id = v.seq;
      cfg_all_masters = v.all;
      f0 = nfills;
      do_read(v.addr, v.mid, d, lat, busy);
      chk((nfills - f0) == int'(v.miss), tg, $sformatf("refill count vec %0d", k),
          32'(nfills - f0), 32'(v.miss));
      chk(d == fdata(v.addr[23:2], gen), tg, $sformatf("data vec %0d", k),
          d, fdata(v.addr[23:2], gen));
      if (v.miss) begin
        eb = eff_bytes(v.units);
        chk(cap_addr == (v.addr & ~24'(eb - 1)), "R3", "window base", 32'(cap_addr),
            32'(v.addr & ~24'(eb - 1)));
        chk(int'(cap_words) == eb / 4, "R4", "fetch words", 32'(cap_words), 32'(eb / 4));
        chk(cap_seq == v.seq, "R3", "sequence id", 32'(cap_seq), 32'(v.seq));
        wait_idle();
      end else begin
        chk(lat == 1, "R2", "hit latency", 32'(lat), 32'd1);
      end
    end

    // R5 and R6: inner-word miss then an immediate second request
    cfg_fetch_units = 8'd200; cfg_seq_id = 4'd4; cfg_all_masters = 1'b1;
    do_read(24'h002008, 4'd0, d, lat, busy);
    chk(busy == 1'b1, "R5", "answered while window still filling", 32'(busy), 32'd1);
    chk(d == fdata(22'h000802, gen), "R5", "early word data", d, fdata(22'h000802, gen));
    f0 = nfills;
    do_read(24'h002000, 4'd0, d, lat, busy);
    chk(busy == 1'b0, "R6", "answered before refill end", 32'(busy), 32'd0);
    chk(lat > 1, "R6", "stall latency", 32'(lat), 32'd2);
    chk(nfills == f0, "R6", "stalled request refilled", 32'(nfills - f0), 32'd0);
    chk(d == fdata(22'h000800, gen), "R6", "stalled hit data", d, fdata(22'h000800, gen));
    wait_idle();

    // R10 and R9: flash content changes, window survives until a full invalidate
    gen = 1;
    pulse_rst(1'b1, 1'b0, 5);
    f0 = nfills;
    do_read(24'h002010, 4'd0, d, lat, busy);
    chk(nfills == f0, "R10", "bus reset alone refilled", 32'(nfills - f0), 32'd0);
    chk(d == fdata(22'h000804, 0), "R10", "old data kept", d, fdata(22'h000804, 0));
    pulse_rst(1'b1, 1'b1, 2);
    f0 = nfills;
    do_read(24'h002010, 4'd0, d, lat, busy);
    chk(nfills == f0, "R10", "short invalidate refilled", 32'(nfills - f0), 32'd0);
    chk(d == fdata(22'h000804, 0), "R10", "old data after short hold", d,
        fdata(22'h000804, 0));
    pulse_rst(1'b1, 1'b1, 3);
    f0 = nfills;
    do_read(24'h002010, 4'd0, d, lat, busy);
    chk(nfills == f0 + 1, "R9", "invalidate did not force refill", 32'(nfills - f0),
        32'd1);
    chk(d == fdata(22'h000804, 1), "R9", "new data after invalidate", d,
        fdata(22'h000804, 1));
    wait_idle();

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule